// File: doc/BRIEF.md
# MSI Write Decoder with Owner Check

This block turns an incoming message-signalled interrupt write into a trigger for one interrupt source. It takes the address, the 16-bit data word and an optional requester partition number. From these it forms a source number and checks it against the configured number of sources. When a partition number comes with the write, the block fetches the source's table entry through a read port and lets the interrupt through only if the entry's owner field equals that partition number. Every write that is let through leaves as a one-cycle trigger pulse. Every write that is dropped leaves as a one-cycle reject pulse with a reason code.

A second input carries fast injections written by software. The written value acts as the address, the data is taken as zero and no ownership check is made. When such an injection has been handled, the block pulses a lock-clear output for the register that holds the injection lock. Two configuration inputs give a base number, which is added to the source number on the trigger, and the source count, which is clamped to the largest count the block supports.

Both write inputs use valid/ready. The block handles one write at a time. A ready is high only while the block is idle. When both inputs are valid in the same cycle, the injection input is taken and the MSI input is held back. A sender must keep valid and its fields steady until it sees ready. The table-entry read port uses a request that is held high, with a steady index, until the response is valid.

Top module: `msi_wr_decoder`

## Requirements
- R1: The source number is address bits [SRC_W+3:4] OR-ed with data bits [4:0]. Address bits outside that slice and data bits [15:5] have no effect.
- R2: A source number greater than or equal to the effective count gives a reject pulse with code 1 and no trigger.
- R3: The effective count is cfg_count when cfg_count is at most MAX_SRC, and MAX_SRC otherwise.
- R4: When msi_pe_valid is high and the source is in range, the block reads the entry at index equal to the source number. It triggers only if ent_rd_owner equals msi_pe. A mismatch gives a reject pulse with code 2.
- R5: When msi_pe_valid is low, no entry read is issued and an in-range source triggers.
- R6: An entry response with ent_rd_ok low gives a reject pulse with code 3 and no trigger.
- R7: An injection uses ffi_value as the address, data 0 and no ownership check. Its outcome pulse (trigger or reject) comes with a one-cycle lock_clr pulse. lock_clr never pulses for an MSI write.
- R8: A trigger is a single-cycle trig_valid pulse carrying trig_src equal to the source number and trig_irq equal to cfg_base plus the source number. A trigger and a reject never occur in the same cycle.
- R9: msi_ready and ffi_ready are high only while no write is in flight. When ffi_valid is high, msi_ready is low. A write that does not read the entry shows its outcome pulse two clock edges after its accepting edge.
- R10: ent_rd_req stays high with a steady ent_rd_idx until a cycle with ent_rd_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msi_valid | input | 1 | MSI write valid |
| msi_ready | output | 1 | MSI write accepted when high with valid |
| msi_addr | input | ADDR_W | MSI write address |
| msi_data | input | 16 | MSI write data |
| msi_pe_valid | input | 1 | Requester partition number supplied |
| msi_pe | input | PE_W | Requester partition number |
| ffi_valid | input | 1 | Injection write valid |
| ffi_ready | output | 1 | Injection write accepted |
| ffi_value | input | ADDR_W | Injected value, used as address |
| cfg_base | input | IRQ_W | Base number added on the trigger |
| cfg_count | input | SRC_W+1 | Configured number of sources |
| ent_rd_req | output | 1 | Entry read request |
| ent_rd_idx | output | SRC_W | Entry index (source number) |
| ent_rd_valid | input | 1 | Entry read response valid |
| ent_rd_ok | input | 1 | Entry read succeeded |
| ent_rd_owner | input | PE_W | Owner field of the entry |
| trig_valid | output | 1 | Trigger pulse |
| trig_src | output | SRC_W | Triggered source number |
| trig_irq | output | IRQ_W | cfg_base plus source number |
| rej_valid | output | 1 | Reject pulse |
| rej_code | output | 2 | 1 range, 2 owner mismatch, 3 read failure |
| lock_clr | output | 1 | Clear pulse for the injection lock |

## Verification
The assertions assume that cfg_count and cfg_base stay steady while a write is in flight. They also assume that ent_rd_valid is raised only while ent_rd_req is high. Both matter for the range property, which compares the trigger with the count of the previous cycle. The bench changes configuration only between writes, when the reference model has no write outstanding. Its entry responder answers only to a live request, after a fixed two-cycle wait, and drops the response after one cycle.

// File: rtl/msi_dec_pkg.sv
package msi_dec_pkg;
  typedef enum logic [1:0] {
    REJ_NONE   = 2'd0,
    REJ_RANGE  = 2'd1,
    REJ_OWNER  = 2'd2,
    REJ_RDFAIL = 2'd3
  } rej_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ
  } dec_state_e;
endpackage

// File: rtl/msi_src_decode.sv
module msi_src_decode #(
  parameter int SRC_W = 16
) (
  input  logic [SRC_W-1:0] addr_slice,
  input  logic [4:0]       data_low,
  output logic [SRC_W-1:0] src
);
  localparam int PAD_W = SRC_W - 5;
  assign src = addr_slice | {{PAD_W{1'b0}}, data_low};
endmodule

// File: rtl/msi_range_gate.sv
module msi_range_gate #(
  parameter int SRC_W   = 16,
  parameter int MAX_SRC = 4096
) (
  input  logic [SRC_W:0]   cfg_count,
  input  logic [SRC_W-1:0] src,
  output logic             in_range
);
  localparam int CNT_W = SRC_W + 1;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_SRC);
  logic [CNT_W-1:0] eff_count;

  assign eff_count = (cfg_count > MAX_CNT) ? MAX_CNT : cfg_count;
  assign in_range  = {1'b0, src} < eff_count;
endmodule

// File: rtl/msi_event_reg.sv
module msi_event_reg
  import msi_dec_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int IRQ_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_trig,
  input  logic             fire_rej,
  input  rej_code_e        fire_code,
  input  logic             fire_lock,
  input  logic [SRC_W-1:0] src,
  input  logic [IRQ_W-1:0] base,
  output logic             trig_valid,
  output logic [SRC_W-1:0] trig_src,
  output logic [IRQ_W-1:0] trig_irq,
  output logic             rej_valid,
  output logic [1:0]       rej_code,
  output logic             lock_clr
);
  localparam int EXT_W = IRQ_W - SRC_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_valid <= 1'b0;
      trig_src   <= '0;
      trig_irq   <= '0;
      rej_valid  <= 1'b0;
      rej_code   <= 2'd0;
      lock_clr   <= 1'b0;
    end else begin
      trig_valid <= fire_trig;
      rej_valid  <= fire_rej;
      lock_clr   <= fire_lock;
      rej_code   <= fire_rej ? fire_code : REJ_NONE;
      if (fire_trig) begin
        trig_src <= src;
        trig_irq <= base + {{EXT_W{1'b0}}, src};
      end
    end
  end
endmodule

// File: rtl/msi_wr_decoder.sv
module msi_wr_decoder
  import msi_dec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SRC_W   = 16,
  parameter int MAX_SRC = 4096,
  parameter int PE_W    = 8,
  parameter int IRQ_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_valid,
  output logic              msi_ready,
  input  logic [ADDR_W-1:0] msi_addr,
  input  logic [15:0]       msi_data,
  input  logic              msi_pe_valid,
  input  logic [PE_W-1:0]   msi_pe,
  input  logic              ffi_valid,
  output logic              ffi_ready,
  input  logic [ADDR_W-1:0] ffi_value,
  input  logic [IRQ_W-1:0]  cfg_base,
  input  logic [SRC_W:0]    cfg_count,
  output logic              ent_rd_req,
  output logic [SRC_W-1:0]  ent_rd_idx,
  input  logic              ent_rd_valid,
  input  logic              ent_rd_ok,
  input  logic [PE_W-1:0]   ent_rd_owner,
  output logic              trig_valid,
  output logic [SRC_W-1:0]  trig_src,
  output logic [IRQ_W-1:0]  trig_irq,
  output logic              rej_valid,
  output logic [1:0]        rej_code,
  output logic              lock_clr
);
  dec_state_e       st, st_n;
  logic             idle, accept;
  logic [SRC_W-1:0] sel_slice, dec_src;
  logic [4:0]       sel_low;
  logic [SRC_W-1:0] job_src;
  logic             job_pe_v, job_ffi;
  logic [PE_W-1:0]  job_pe;
  logic             in_range;
  logic             fire_trig, fire_rej, fire_lock;
  rej_code_e        fire_code;

  assign idle      = (st == ST_IDLE);
  assign ffi_ready = idle;
  assign msi_ready = idle && !ffi_valid;
  assign accept    = idle && (ffi_valid || msi_valid);

  // injection wins; its data is taken as zero
  assign sel_slice = ffi_valid ? ffi_value[4 +: SRC_W] : msi_addr[4 +: SRC_W];
  assign sel_low   = ffi_valid ? 5'd0 : msi_data[4:0];

  msi_src_decode #(.SRC_W(SRC_W)) u_decode (
    .addr_slice (sel_slice),
    .data_low   (sel_low),
    .src        (dec_src)
  );

  msi_range_gate #(.SRC_W(SRC_W), .MAX_SRC(MAX_SRC)) u_range (
    .cfg_count (cfg_count),
    .src       (job_src),
    .in_range  (in_range)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      job_src  <= '0;
      job_pe_v <= 1'b0;
      job_pe   <= '0;
      job_ffi  <= 1'b0;
    end else begin
      st <= st_n;
      if (accept) begin
        job_src  <= dec_src;
        job_ffi  <= ffi_valid;
        job_pe_v <= !ffi_valid && msi_pe_valid;
        job_pe   <= msi_pe;
      end
    end
  end

  always_comb begin
    st_n      = st;
    fire_trig = 1'b0;
    fire_rej  = 1'b0;
    fire_code = REJ_NONE;
    case (st)
      ST_IDLE:  if (accept) st_n = ST_CHECK;
      ST_CHECK: begin
        if (!in_range) begin
          fire_rej  = 1'b1;
          fire_code = REJ_RANGE;
          st_n      = ST_IDLE;
        end else if (job_pe_v) begin
          st_n = ST_READ;
        end else begin
          fire_trig = 1'b1;
          st_n      = ST_IDLE;
        end
      end
      ST_READ: begin
        if (ent_rd_valid) begin
          st_n = ST_IDLE;
          if (!ent_rd_ok) begin
            fire_rej  = 1'b1;
            fire_code = REJ_RDFAIL;
          end else if (ent_rd_owner != job_pe) begin
            fire_rej  = 1'b1;
            fire_code = REJ_OWNER;
          end else begin
            fire_trig = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign fire_lock  = job_ffi && (fire_trig || fire_rej);
  assign ent_rd_req = (st == ST_READ);
  assign ent_rd_idx = job_src;

  msi_event_reg #(.SRC_W(SRC_W), .IRQ_W(IRQ_W)) u_event (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_trig  (fire_trig),
    .fire_rej   (fire_rej),
    .fire_code  (fire_code),
    .fire_lock  (fire_lock),
    .src        (job_src),
    .base       (cfg_base),
    .trig_valid (trig_valid),
    .trig_src   (trig_src),
    .trig_irq   (trig_irq),
    .rej_valid  (rej_valid),
    .rej_code   (rej_code),
    .lock_clr   (lock_clr)
  );
endmodule

// File: rtl/msi_wr_decoder_chk.sv
module msi_wr_decoder_chk #(
  parameter int SRC_W   = 16,
  parameter int MAX_SRC = 4096
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msi_valid,
  input logic             msi_ready,
  input logic             ffi_valid,
  input logic             ffi_ready,
  input logic [SRC_W:0]   cfg_count,
  input logic             ent_rd_req,
  input logic [SRC_W-1:0] ent_rd_idx,
  input logic             ent_rd_valid,
  input logic             ent_rd_ok,
  input logic             trig_valid,
  input logic [SRC_W-1:0] trig_src,
  input logic             rej_valid,
  input logic [1:0]       rej_code,
  input logic             lock_clr
);
  localparam logic [SRC_W:0] LIMIT = (SRC_W+1)'(MAX_SRC);
  logic [SRC_W:0] clamped;
  assign clamped = (cfg_count > LIMIT) ? LIMIT : cfg_count;

  assert_ffi_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ffi_valid |-> !msi_ready);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && msi_ready) || (ffi_valid && ffi_ready) |=> !msi_ready && !ffi_ready);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> !trig_valid);

  assert_no_trig_and_rej_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_valid && rej_valid));

  assert_trig_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> ({1'b0, trig_src} < $past(clamped)));

  assert_read_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ent_rd_req && !ent_rd_valid |=> ent_rd_req && $stable(ent_rd_idx));

  assert_lock_with_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_clr |-> (trig_valid || rej_valid));

  assert_rdfail_reason_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid && rej_code == 2'd3 |-> $past(ent_rd_valid && !ent_rd_ok));
endmodule

bind msi_wr_decoder msi_wr_decoder_chk #(.SRC_W(SRC_W), .MAX_SRC(MAX_SRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .msi_valid    (msi_valid),
  .msi_ready    (msi_ready),
  .ffi_valid    (ffi_valid),
  .ffi_ready    (ffi_ready),
  .cfg_count    (cfg_count),
  .ent_rd_req   (ent_rd_req),
  .ent_rd_idx   (ent_rd_idx),
  .ent_rd_valid (ent_rd_valid),
  .ent_rd_ok    (ent_rd_ok),
  .trig_valid   (trig_valid),
  .trig_src     (trig_src),
  .rej_valid    (rej_valid),
  .rej_code     (rej_code),
  .lock_clr     (lock_clr)
);

// File: tb/msi_wr_decoder_test.sv
`timescale 1ns/1ps
module msi_wr_decoder_test;
  localparam int ADDR_W = 32, SRC_W = 16, MAX_SRC = 4096, PE_W = 8, IRQ_W = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msi_valid = 1'b0, msi_pe_valid = 1'b0, ffi_valid = 1'b0;
  logic msi_ready, ffi_ready;
  logic [ADDR_W-1:0] msi_addr = '0, ffi_value = '0;
  logic [15:0] msi_data = '0;
  logic [PE_W-1:0] msi_pe = '0;
  logic [IRQ_W-1:0] cfg_base = '0;
  logic [SRC_W:0] cfg_count = '0;
  logic ent_rd_req, ent_rd_valid = 1'b0, ent_rd_ok = 1'b0;
  logic [SRC_W-1:0] ent_rd_idx;
  logic [PE_W-1:0] ent_rd_owner = '0;
  logic trig_valid, rej_valid, lock_clr;
  logic [SRC_W-1:0] trig_src;
  logic [IRQ_W-1:0] trig_irq;
  logic [1:0] rej_code;

  always #10 clk = ~clk;

  msi_wr_decoder #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .MAX_SRC(MAX_SRC), .PE_W(PE_W), .IRQ_W(IRQ_W)) uut (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data), .msi_pe_valid(msi_pe_valid), .msi_pe(msi_pe),
    .ffi_valid(ffi_valid), .ffi_ready(ffi_ready), .ffi_value(ffi_value),
    .cfg_base(cfg_base), .cfg_count(cfg_count),
    .ent_rd_req(ent_rd_req), .ent_rd_idx(ent_rd_idx), .ent_rd_valid(ent_rd_valid),
    .ent_rd_ok(ent_rd_ok), .ent_rd_owner(ent_rd_owner),
    .trig_valid(trig_valid), .trig_src(trig_src), .trig_irq(trig_irq),
    .rej_valid(rej_valid), .rej_code(rej_code), .lock_clr(lock_clr));

  int vectors = 0, miscompares = 0, pending = 0, lat = 0;
  bit finished = 0, rd_expected = 0;
  int rd_exp_idx = 0;
  int q_kind[$], q_src[$], q_irq[$], q_code[$], q_lock[$];
  string q_req[$];

  function automatic int owner_of(int s); return (s * 3 + 1) & 255; endfunction
  function automatic bit fails(int s); return (s % 7) == 3; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model: predicts the outcome of one accepted write
  task automatic model(input logic [31:0] addr, input logic [15:0] data, input bit pe_v,
                       input int pe, input bit ffi, input string req);
    int s, eff, kind, code;
    s   = int'((addr >> 4) & 32'hFFFF) | int'(data & 16'h1F);
    eff = (int'(cfg_count) > MAX_SRC) ? MAX_SRC : int'(cfg_count);
    kind = 0; code = 0;
    if (s >= eff) begin kind = 1; code = 1; end
    else if (pe_v) begin
      rd_expected = 1; rd_exp_idx = s;
      if (fails(s)) begin kind = 1; code = 3; end
      else if (owner_of(s) != pe) begin kind = 1; code = 2; end
    end
    q_kind.push_back(kind); q_src.push_back(s);
    q_irq.push_back((int'(cfg_base) + s) & 24'hFFFFFF);
    q_code.push_back(code); q_lock.push_back(int'(ffi)); q_req.push_back(req);
    pending++;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    if (trig_valid || rej_valid) begin
      if (q_kind.size() == 0) check(0, "R8 unexpected event", int'(trig_valid), 0);
      else begin
        int k, s, ir, c, l; string r;
        k = q_kind.pop_front(); s = q_src.pop_front(); ir = q_irq.pop_front();
        c = q_code.pop_front(); l = q_lock.pop_front(); r = q_req.pop_front();
        pending--;
        check(trig_valid == (k == 0) && rej_valid == (k == 1), {r, " kind"}, int'(rej_valid), k);
        if (k == 0) begin
          check(int'(trig_src) == s, {r, " trig_src"}, int'(trig_src), s);
          check(int'(trig_irq) == ir, {r, " R8 trig_irq"}, int'(trig_irq), ir);
        end else check(int'(rej_code) == c, {r, " rej_code"}, int'(rej_code), c);
        check(int'(lock_clr) == l, {r, " R7 lock_clr"}, int'(lock_clr), l);
      end
    end else begin
      check(!lock_clr, "R7 stray lock_clr", int'(lock_clr), 0);
      if (pending > 0)
        check(!msi_ready && !ffi_ready, "R9 ready while busy", int'({msi_ready, ffi_ready}), 0);
    end
  end

  // entry memory: answers two cycles into a request, for one cycle
  always @(negedge clk) if (rst_n) begin
    if (ent_rd_valid) begin ent_rd_valid = 0; lat = 0; end
    else if (ent_rd_req) begin
      lat++;
      if (lat == 1) begin
        check(rd_expected, "R5 read issued", 1, int'(rd_expected));
        check(int'(ent_rd_idx) == rd_exp_idx, "R4 entry index", int'(ent_rd_idx), rd_exp_idx);
      end
      if (lat == 2) begin
        ent_rd_valid = 1; ent_rd_ok = !fails(int'(ent_rd_idx));
        ent_rd_owner = PE_W'(owner_of(int'(ent_rd_idx)));
        rd_expected = 0;
      end
    end else lat = 0;
  end

  task automatic send_msi(input logic [31:0] a, input logic [15:0] d, input bit pv,
                          input int pe, input string req);
    @(negedge clk);
    msi_addr = a; msi_data = d; msi_pe_valid = pv; msi_pe = PE_W'(pe); msi_valid = 1;
    #1 check(msi_ready, "R9 msi_ready idle", int'(msi_ready), 1);
    @(posedge clk); #1 model(a, d, pv, pe, 0, req);
    @(negedge clk); msi_valid = 0;
    wait (pending == 0);
  endtask

  task automatic send_ffi(input logic [31:0] v, input string req);
    @(negedge clk);
    ffi_value = v; ffi_valid = 1;
    #1 check(ffi_ready, "R9 ffi_ready idle", int'(ffi_ready), 1);
    @(posedge clk); #1 model(v, 16'h0, 0, 0, 1, req);
    @(negedge clk); ffi_valid = 0;
    wait (pending == 0);
  endtask

  task automatic set_cfg(input int cnt, input int base);
    @(negedge clk); cfg_count = (SRC_W+1)'(cnt); cfg_base = IRQ_W'(base);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1; miscompares++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!trig_valid && !rej_valid && !lock_clr && !ent_rd_req, "R8 reset outputs",
          int'({trig_valid, rej_valid, lock_clr, ent_rd_req}), 0);
    rst_n = 1;
    @(negedge clk);
    check(msi_ready && ffi_ready, "R9 ready after reset", int'({msi_ready, ffi_ready}), 3);

    set_cfg(100, 24'h1000);
    send_msi(32'h0000_0350, 16'h0003, 0, 0, "R1 R5 basic");
    send_msi(32'h0000_0120, 16'h000D, 0, 0, "R1 overlap or");
    send_msi(32'hF000_0370, 16'hFFE1, 0, 0, "R1 ignored bits");
    send_msi(32'h0000_0630, 16'h0000, 0, 0, "R2 src 99 edge");
    send_msi(32'h0000_0640, 16'h0000, 0, 0, "R2 src 100 reject");
    send_msi(32'h0000_0000, 16'h001F, 0, 0, "R5 no pe");

    set_cfg(70000, 24'hFFFFF0);
    send_msi(32'h0000_FFF0, 16'h0000, 0, 0, "R3 clamp 4095 ok");
    send_msi(32'h0001_0000, 16'h0000, 0, 0, "R3 clamp 4096 reject");
    set_cfg(4096, 24'h20);
    send_msi(32'h0001_0000, 16'h0000, 0, 0, "R3 exact max reject");

    set_cfg(200, 24'h300);
    send_msi(32'h0000_0050, 16'h0000, 1, owner_of(5), "R4 owner match");
    send_msi(32'h0000_0050, 16'h0000, 1, owner_of(5) ^ 1, "R4 owner mismatch");
    send_msi(32'h0000_00A0, 16'h0000, 1, owner_of(10), "R6 read fail");
    send_msi(32'h0000_0C80, 16'h0000, 1, 0, "R2 range before read");

    send_ffi(32'h0000_0A00, "R7 ffi trig");
    send_ffi(32'h0000_00A0, "R7 ffi no owner check");
    send_ffi(32'h0000_1000, "R7 ffi range reject");

    // both inputs valid together: injection first, MSI afterwards
    @(negedge clk);
    ffi_value = 32'h0000_0070; ffi_valid = 1;
    msi_addr = 32'h0000_0080; msi_data = 16'h0001; msi_pe_valid = 0; msi_valid = 1;
    #1 check(ffi_ready && !msi_ready, "R9 ffi priority", int'({ffi_ready, msi_ready}), 2);
    @(posedge clk); #1 model(32'h70, 16'h0, 0, 0, 1, "R9 prio ffi");
    model(32'h80, 16'h1, 0, 0, 0, "R9 prio msi");
    @(negedge clk); ffi_valid = 0;
    wait (pending == 1);
    @(posedge clk); @(negedge clk); msi_valid = 0;
    wait (pending == 0);

    set_cfg(0, 0);
    send_msi(32'h0, 16'h0, 0, 0, "R2 zero count");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule